// File: doc/BRIEF.md
# USB Pipe Completion Event Register

This block sits between a USB transaction engine and a CPU. For each of up to eight endpoint pipes it watches the handshake outcome that the engine reports at the end of every transaction attempt. It decides from the current role, host or peripheral, whether that attempt finished the transaction. A finishing attempt sets a sticky flag for that pipe in an 8-bit status word. An attempt that does not finish is counted as a retry.

Pipe 0 carries control traffic, so it reports completions in both directions. Pipes 1 to 7 report only transfers in the write direction. The CPU reads the status word through a small register port, and the read clears it. A level interrupt stays high while any flag that the mask allows is set. A saturating retry counter for each pipe can be read for debug.

Top module: `usb_pipe_evt_reg`

## Requirements
- R1: Status bit n belongs to pipe n. Pipe 0 can set its bit whatever the value of `evt_wr_dir`. A pipe n > 0 reacts only when `evt_wr_dir[n]` is 1: with `evt_wr_dir[n]` at 0 an event changes neither its flag nor its retry count.
- R2: In host role (`host_role`=1), outcome codes ACK (0), STALL (2) and NO_REPLY (3) finish the transaction and set the pipe's flag. The code for pipe n is `evt_code[2n+1:2n]`.
- R3: In host role, outcome NAK (1) does not set a flag. It counts as one retry of that pipe.
- R4: In peripheral role (`host_role`=0), only ACK (0) and STALL (2) finish a transaction. NAK (1) and NO_REPLY (3) count as retries and set no flag.
- R5: A read of address 0 returns the flags in `cpu_rdata` on the cycle after `cpu_rd`, and clears them in the same access. Flags are 0 after reset and stay set until they are read.
- R6: An event that finishes a transaction in the same cycle as a clearing read is not part of the returned value, and it stays set after the read.
- R7: A write to address 0 does not change the flags.
- R8: While `enable` is 0, events change neither the flags nor the retry counts.
- R9: `irq` is a registered level output. It is high exactly when some flag is set whose bit in the mask is 1. The mask sits at address 1, can be read and written, and resets to all ones.
- R10: Each pipe's retry count goes up by one on every non-finishing event, saturates at 255 and goes back to 0 when the pipe finishes a transaction. Writing a pipe index to address 2 selects a pipe, and address 3 then reads that pipe's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Global enable for event capture |
| host_role | input | 1 | 1 = host role, 0 = peripheral role |
| evt_vld | input | 8 | One strobe per pipe: an outcome is present this cycle |
| evt_code | input | 16 | Two-bit outcome per pipe (0 ACK, 1 NAK, 2 STALL, 3 NO_REPLY) |
| evt_wr_dir | input | 8 | Per pipe: the transaction was in the write direction |
| cpu_addr | input | 2 | Register address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The main sweep covers every combination of role, pipe, outcome code and direction bit. After each event the bench checks the interrupt, the status read and the pipe's retry count. This separates finishing outcomes from retrying outcomes in each role, and it separates pipe 0 from the write-only pipes. Further patterns are a run of back-to-back NAKs long enough to reach saturation, an event that lands on the same cycle as a clearing read, a write to the status address, capture with the enable low, and several mask settings. These show that the flags are sticky, that no event is lost, and that the interrupt follows the mask.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  typedef enum logic [1:0] {
    HS_ACK      = 2'd0,
    HS_NAK      = 2'd1,
    HS_STALL    = 2'd2,
    HS_NO_REPLY = 2'd3
  } hs_code_t;

  localparam logic [1:0] REG_STATUS = 2'd0;
  localparam logic [1:0] REG_MASK   = 2'd1;
  localparam logic [1:0] REG_SEL    = 2'd2;
  localparam logic [1:0] REG_RETRY  = 2'd3;
endpackage

// File: rtl/usb_evt_judge.sv
module usb_evt_judge
  import usb_evt_pkg::*;
#(
  parameter bit IS_PIPE0 = 1'b0
) (
  input  logic       enable,
  input  logic       host_role,
  input  logic       vld,
  input  logic [1:0] code,
  input  logic       wr_dir,
  output logic       finish,
  output logic       retry
);
  logic in_scope;
  logic ends_xact;

  always_comb begin
    in_scope = enable && vld && (IS_PIPE0 || wr_dir);
    if (host_role)
      ends_xact = (hs_code_t'(code) != HS_NAK);
    else
      ends_xact = (hs_code_t'(code) == HS_ACK) || (hs_code_t'(code) == HS_STALL);
    finish = in_scope && ends_xact;
    retry  = in_scope && !ends_xact;
  end
endmodule

// File: rtl/usb_evt_retry_cnt.sv
module usb_evt_retry_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_retry,
  input  logic             hit_finish,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (hit_finish)
      count <= '0;
    else if (hit_retry && count != CNT_MAX)
      count <= count + 1'b1;
  end

  assert_cnt_sat_R10: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && !hit_finish) |=> (count == CNT_MAX));
  assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (rst)
    hit_finish |=> (count == '0));
endmodule

// File: rtl/usb_pipe_evt_reg.sv
module usb_pipe_evt_reg
  import usb_evt_pkg::*;
#(
  parameter int NUM_PIPES = 8,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enable,
  input  logic                   host_role,
  input  logic [NUM_PIPES-1:0]   evt_vld,
  input  logic [2*NUM_PIPES-1:0] evt_code,
  input  logic [NUM_PIPES-1:0]   evt_wr_dir,
  input  logic [1:0]             cpu_addr,
  input  logic                   cpu_rd,
  input  logic                   cpu_wr,
  input  logic [DATA_W-1:0]      cpu_wdata,
  output logic [DATA_W-1:0]      cpu_rdata,
  output logic                   irq
);
  localparam int SEL_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1;

  logic [NUM_PIPES-1:0] set_vec;
  logic [NUM_PIPES-1:0] retry_vec;
  logic [NUM_PIPES-1:0] flags_q, flags_nxt;
  logic [NUM_PIPES-1:0] mask_q, mask_nxt;
  logic [SEL_W-1:0]     sel_q;
  logic [CNT_W-1:0]     cnt_arr [NUM_PIPES];
  logic                 clr;
  logic [DATA_W-1:0]    rd_mux;
  logic                 unused_wdata;

  assign unused_wdata = ^cpu_wdata;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PIPES; gi++) begin : g_pipe
      usb_evt_judge #(.IS_PIPE0(gi == 0)) judge_i (
        .enable    (enable),
        .host_role (host_role),
        .vld       (evt_vld[gi]),
        .code      (evt_code[2*gi +: 2]),
        .wr_dir    (evt_wr_dir[gi]),
        .finish    (set_vec[gi]),
        .retry     (retry_vec[gi])
      );
      usb_evt_retry_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .hit_retry  (retry_vec[gi]),
        .hit_finish (set_vec[gi]),
        .count      (cnt_arr[gi])
      );
    end
  endgenerate

  always_comb begin
    clr       = cpu_rd && (cpu_addr == REG_STATUS);
    flags_nxt = (clr ? '0 : flags_q) | set_vec;
    mask_nxt  = (cpu_wr && cpu_addr == REG_MASK) ? cpu_wdata[NUM_PIPES-1:0] : mask_q;
  end

  always_comb begin
    rd_mux = '0;
    case (cpu_addr)
      REG_STATUS: rd_mux[NUM_PIPES-1:0] = flags_q;
      REG_MASK:   rd_mux[NUM_PIPES-1:0] = mask_q;
      REG_SEL:    rd_mux[SEL_W-1:0]     = sel_q;
      default:    rd_mux[CNT_W-1:0]     = cnt_arr[sel_q];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      mask_q    <= '1;
      sel_q     <= '0;
      irq       <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      flags_q <= flags_nxt;
      mask_q  <= mask_nxt;
      irq     <= |(flags_nxt & mask_nxt);
      if (cpu_wr && cpu_addr == REG_SEL)
        sel_q <= cpu_wdata[SEL_W-1:0];
      if (cpu_rd)
        cpu_rdata <= rd_mux;
    end
  end

  assert_evt_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  assert_gated_R8: assert property (@(posedge clk) disable iff (rst)
    (!enable && !clr) |=> $stable(flags_q));
  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags_q & mask_q));
endmodule

// File: tb/usb_pipe_evt_reg_tb.sv
`timescale 1ns/1ps
module usb_pipe_evt_reg_tb_top;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          host_role = 1'b1;
  logic [NP-1:0] evt_vld = '0;
  logic [2*NP-1:0] evt_code = '0;
  logic [NP-1:0] evt_wr_dir = '0;
  logic [1:0]    cpu_addr = '0;
  logic          cpu_rd = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    cpu_rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int exp_cnt [NP];

  always #2.5 clk = ~clk;

  usb_pipe_evt_reg dut_i (
    .clk(clk), .rst(rst), .enable(enable), .host_role(host_role),
    .evt_vld(evt_vld), .evt_code(evt_code), .evt_wr_dir(evt_wr_dir),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic evt(input int p, input int code, input bit wr, input int cycles);
    @(negedge clk);
    evt_vld = '0; evt_vld[p] = 1'b1;
    evt_code = '0; evt_code[2*p +: 2] = code[1:0];
    evt_wr_dir = '0; evt_wr_dir[p] = wr;
    repeat (cycles) @(negedge clk);
    evt_vld = '0;
  endtask

  function automatic bit finishes(input bit host, input int code);
    if (host) return code != 1;
    return (code == 0) || (code == 2);
  endfunction

  task automatic read_cnt(input int p, output logic [7:0] d);
    do_write(2'd2, p[7:0]);
    do_read(2'd3, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int exp_flags;
    for (int i = 0; i < NP; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 irq after reset", irq, 0);
    do_read(2'd0, d); chk("R5 status after reset", d, 0);
    do_read(2'd1, d); chk("R9 mask after reset", d, 8'hFF);
    enable = 1'b1;

    // Main sweep R1 R2 R3 R4 R10
    for (int role = 0; role < 2; role++) begin
      host_role = role[0];
      for (int p = 0; p < NP; p++)
        for (int c = 0; c < 4; c++)
          for (int w = 0; w < 2; w++) begin
            bit act_ok, fin;
            act_ok = (p == 0) || (w == 1);
            fin = act_ok && finishes(role[0], c);
            if (act_ok) begin
              if (fin) exp_cnt[p] = 0;
              else if (exp_cnt[p] < 255) exp_cnt[p]++;
            end
            exp_flags = fin ? (1 << p) : 0;
            evt(p, c, w[0], 1);
            chk(role ? "R2 R3 host irq" : "R4 periph irq", irq, fin);
            do_read(2'd0, d);
            chk(role ? "R1 R2 R3 host status" : "R1 R4 periph status", d, exp_flags);
            read_cnt(p, d);
            chk("R10 retry count", d, exp_cnt[p]);
          end
    end

    // R10 saturation then clear
    host_role = 1'b1;
    evt(3, 1, 1'b1, 260);
    read_cnt(3, d); chk("R10 saturate", d, 255);
    do_read(2'd0, d); chk("R3 no flag on NAKs", d, 0);
    evt(3, 0, 1'b1, 1);
    read_cnt(3, d); chk("R10 clear on finish", d, 0);
    do_read(2'd0, d); chk("R2 ACK flag", d, 8'h08);

    // R6 event during clearing read
    evt(1, 2, 1'b1, 1);
    @(negedge clk);
    cpu_addr = 2'd0; cpu_rd = 1'b1;
    evt_vld = 8'h04; evt_code = 16'h0000; evt_wr_dir = 8'h04;
    @(negedge clk);
    cpu_rd = 1'b0; evt_vld = '0;
    chk("R6 returned value", cpu_rdata, 8'h02);
    chk("R6 irq kept", irq, 1);
    do_read(2'd0, d); chk("R6 event retained", d, 8'h04);

    // R7 write to status
    evt(5, 3, 1'b1, 1);
    do_write(2'd0, 8'h00);
    do_write(2'd0, 8'hFF);
    do_read(2'd0, d); chk("R7 write ignored", d, 8'h20);

    // R8 enable low
    enable = 1'b0;
    evt(6, 0, 1'b1, 1);
    evt(6, 1, 1'b1, 3);
    chk("R8 irq while disabled", irq, 0);
    do_read(2'd0, d); chk("R8 no flag while disabled", d, 0);
    read_cnt(6, d); chk("R8 no retry while disabled", d, exp_cnt[6]);
    enable = 1'b1;

    // R9 mask
    do_write(2'd1, 8'h00);
    do_read(2'd1, d); chk("R9 mask readback", d, 0);
    evt(2, 0, 1'b1, 1);
    chk("R9 masked irq low", irq, 0);
    do_write(2'd1, 8'h04);
    chk("R9 unmask raises irq", irq, 1);
    do_write(2'd1, 8'hFB);
    chk("R9 other bits no irq", irq, 0);
    do_read(2'd0, d); chk("R9 flag still held", d, 8'h04);
    do_write(2'd1, 8'hFF);
    chk("R9 irq low after clear", irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule